// File: doc/BRIEF.md
# Serial Command Front End for a Single-Wiper Digital Potentiometer

This block sits between a four-wire serial host bus (SPI mode 0 style) and the register logic of a single-wiper digital potentiometer. It oversamples the serial clock, chip select, data-in and a pause input in the block's system clock domain. From the incoming bytes it checks an identification byte against a fixed device-type nibble and the two strapped address pins, then decodes an instruction byte. From that it issues one-cycle command strobes to a separate register bank: wiper and data-register writes, reads, transfers between the wiper and the data registers, and single-step moves of the wiper.

Frames come in three lengths: two bytes for transfers, three bytes for reads and writes, and an open-ended step stream that lasts until chip select rises. For reads, the register bank returns the selected byte combinationally on `rd_data` in the cycle the read strobe is high, and the block shifts it out on `so`. The pause input freezes the frame without losing its position. All serial inputs are assumed to be already synchronised to `clk`.

Top module: `pot_spi_front`

## Requirements
- R1: The first byte after a chip-select fall must be, MSB first, 0101 then 00 then the two address bits equal to `dev_addr`. On any mismatch the rest of the frame issues no command and `so_oe` stays low until chip select rises.
- R2: The second byte holds the opcode in bits 7:4, a register index in bits 3:2 and a bank index in bits 1:0. Register and bank are presented on `cmd_reg` and `cmd_bank` with each data-register command.
- R3: Opcode 1010 (wiper write) and opcode 1100 (data-register write) take three bytes. After the last bit of byte three, exactly one `cmd_valid` pulse is issued, with `cmd_kind` 0 or 1 respectively and `cmd_data` equal to byte three.
- R4: Opcode 1001 (wiper read) and opcode 1011 (data-register read) issue `cmd_kind` 2 or 3 once the instruction byte is complete. The `rd_data` value present with that pulse is returned on `so` MSB first during byte three. `so` changes only after falling SCK edges, and `so_oe` is low during the first two bytes.
- R5: Opcode 1101 (data register to wiper) issues `cmd_kind` 4 and opcode 1110 (wiper to data register) issues `cmd_kind` 5, both as two-byte frames. Either one issues nothing unless the bank field is 0.
- R6: After opcode 0010, every rising SCK edge until chip select rises issues one command: `cmd_kind` 6 (step toward high end) when `si` is 1, and `cmd_kind` 7 (step toward low end) when `si` is 0.
- R7: `hold_n` taken low while SCK is low ignores all SCK edges and drives `so_oe` low. Taken high while SCK is low, it resumes the frame at the same bit.
- R8: After reset, no frame is decoded until chip select has been seen high and then low.
- R9: A frame ended by chip select rising before the last bit of its data byte issues no command.
- R10: An opcode not listed above issues no command for the rest of the frame.
- R11: `so_oe` is low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause, active low |
| dev_addr | input | 2 | Strapped slave address |
| rd_data | input | 8 | Read value from register bank, valid while a read strobe is high |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 3 | Command code (see R3 to R6) |
| cmd_reg | output | 2 | Register index |
| cmd_bank | output | 2 | Bank index |
| cmd_data | output | 8 | Write data |

## Verification
A wrong bit counter or frame state shows at the ports within the frame in which it occurs. A command either appears one byte too early or too late, carries the wrong kind, or a read byte comes out rotated on `so`. Errors in the pause or edge logic show up as shifted data bytes after a paused frame, or as an extra step strobe in a stream. Because every frame is compared against a per-frame list of the strobes the bench expects, any stray or missing strobe is reported at the end of that same frame.

// File: rtl/pot_spi_pkg.sv
// Shared constants and types for the potentiometer serial front end.
// Assumes byte-wide frames and a two-bit slave address.
package pot_spi_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int ADDR_W = 2;

    typedef enum logic [2:0] {
        K_WR_WIPER = 3'd0,
        K_WR_DREG  = 3'd1,
        K_RD_WIPER = 3'd2,
        K_RD_DREG  = 3'd3,
        K_DR_TO_W  = 3'd4,
        K_W_TO_DR  = 3'd5,
        K_STEP_UP  = 3'd6,
        K_STEP_DN  = 3'd7
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ID, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_DEAD
    } frame_st_e;

    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_DREG  = 4'b1011;
    localparam logic [3:0] OP_WR_DREG  = 4'b1100;
    localparam logic [3:0] OP_DR_TO_W  = 4'b1101;
    localparam logic [3:0] OP_W_TO_DR  = 4'b1110;
    localparam logic [3:0] OP_STEP     = 4'b0010;
endpackage

// File: rtl/pot_spi_edges.sv
// Turns the oversampled serial clock and chip select into qualified
// single-cycle events, and tracks the pause state.
// Assumes all inputs are already synchronous to clk; SCK idles low.
module pot_spi_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic frame_start,
    output logic sck_rise,
    output logic sck_fall,
    output logic paused
);
    logic cs_q;
    logic sck_q;

    // Previous-sample registers; cs_q resets low so a select held low
    // across reset never counts as a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sck_q  <= 1'b0;
            paused <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            if (cs_n)
                paused <= 1'b0;
            else if (!sck)
                paused <= !hold_n;
        end
    end

    assign frame_start = cs_q & ~cs_n;
    assign sck_rise    = sck & ~sck_q & ~paused & ~cs_n;
    assign sck_fall    = ~sck & sck_q & ~paused & ~cs_n;
endmodule

// File: rtl/pot_spi_decoder.sv
// Frame decoder: counts bits, assembles bytes, checks the identity byte,
// decodes the instruction and issues one-cycle command strobes.
// Assumes sck_rise/frame_start come from pot_spi_edges.
module pot_spi_decoder
    import pot_spi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              si,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              frame_start,
    input  logic              sck_rise,
    input  logic              paused,
    output logic              cmd_valid,
    output cmd_kind_e         cmd_kind,
    output logic [1:0]        cmd_reg,
    output logic [1:0]        cmd_bank,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              out_phase,
    output logic              bit_cnt_zero
);
    frame_st_e         state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] sh;
    logic [3:0]        op_q;
    logic [1:0]        reg_q, bank_q;
    logic [BYTE_W-1:0] byte_in;
    logic              done, issue;
    cmd_kind_e         ikind;
    logic [1:0]        ireg, ibank;
    logic              id_ok;

    assign byte_in = {sh, si};
    assign done    = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign id_ok   = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:2] == 2'b00)
                     && (byte_in[1:0] == dev_addr);
    assign ireg    = (state == ST_INSTR) ? byte_in[3:2] : reg_q;
    assign ibank   = (state == ST_INSTR) ? byte_in[1:0] : bank_q;

    // Next frame state and the command a completed bit would issue.
    always_comb begin
        nxt   = state;
        issue = 1'b0;
        ikind = K_WR_WIPER;
        case (state)
            ST_ID: if (done) nxt = id_ok ? ST_INSTR : ST_DEAD;
            ST_INSTR: if (done) begin
                case (byte_in[7:4])
                    OP_WR_WIPER, OP_WR_DREG: nxt = ST_WDATA;
                    OP_RD_WIPER: begin nxt = ST_RDATA; issue = 1'b1; ikind = K_RD_WIPER; end
                    OP_RD_DREG:  begin nxt = ST_RDATA; issue = 1'b1; ikind = K_RD_DREG;  end
                    OP_DR_TO_W: begin
                        nxt = ST_DEAD; issue = (byte_in[1:0] == 2'b00); ikind = K_DR_TO_W;
                    end
                    OP_W_TO_DR: begin
                        nxt = ST_DEAD; issue = (byte_in[1:0] == 2'b00); ikind = K_W_TO_DR;
                    end
                    OP_STEP: nxt = ST_STEP;
                    default: nxt = ST_DEAD;
                endcase
            end
            ST_WDATA: if (done) begin
                nxt   = ST_DEAD;
                issue = 1'b1;
                ikind = (op_q == OP_WR_WIPER) ? K_WR_WIPER : K_WR_DREG;
            end
            ST_RDATA: if (done) nxt = ST_DEAD;
            ST_STEP: begin
                issue = 1'b1;
                ikind = si ? K_STEP_UP : K_STEP_DN;
            end
            default: nxt = state;
        endcase
    end

    // Frame registers and the registered command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            sh        <= '0;
            op_q      <= '0;
            reg_q     <= '0;
            bank_q    <= '0;
            cmd_valid <= 1'b0;
            cmd_kind  <= K_WR_WIPER;
            cmd_reg   <= '0;
            cmd_bank  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_n) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else if (frame_start) begin
                state   <= ST_ID;
                bit_cnt <= '0;
            end else if (sck_rise && state != ST_IDLE) begin
                bit_cnt <= bit_cnt + 1'b1;
                sh      <= byte_in[BYTE_W-2:0];
                state   <= nxt;
                if (state == ST_INSTR && done) begin
                    op_q   <= byte_in[7:4];
                    reg_q  <= byte_in[3:2];
                    bank_q <= byte_in[1:0];
                end
                if (issue) begin
                    cmd_valid <= 1'b1;
                    cmd_kind  <= ikind;
                    cmd_reg   <= ireg;
                    cmd_bank  <= ibank;
                    cmd_data  <= byte_in;
                end
            end
        end
    end

    assign out_phase    = (state == ST_RDATA);
    assign bit_cnt_zero = (bit_cnt == '0);

    // R9: a strobe only follows an edge taken while the device was selected.
    p_cmd_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(!cs_n));

    // R5: transfers only ever leave with bank 0.
    p_xfer_bank0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_kind == K_DR_TO_W || cmd_kind == K_W_TO_DR)) |-> (cmd_bank == 2'b00));

    // R7: while paused the bit position does not move.
    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(paused) && $past(!cs_n)) |-> $stable(bit_cnt));
endmodule

// File: rtl/pot_spi_txshift.sv
// Read-data shifter: captures the register bank's byte on a read strobe
// and presents it MSB first, advancing after each falling SCK edge except
// the one that precedes the first data bit.
module pot_spi_txshift
    import pot_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              sck_fall,
    input  logic              bit_cnt_zero,
    input  logic              out_phase,
    input  logic              cs_n,
    input  logic              paused,
    output logic              so,
    output logic              so_oe
);
    logic [BYTE_W-1:0] tx;
    logic              loaded;

    // Capture, hold or shift the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx     <= '0;
            loaded <= 1'b0;
        end else if (load) begin
            tx     <= load_data;
            loaded <= 1'b1;
        end else if (!out_phase) begin
            loaded <= 1'b0;
        end else if (sck_fall && !bit_cnt_zero) begin
            tx <= {tx[BYTE_W-2:0], 1'b0};
        end
    end

    assign so    = tx[BYTE_W-1];
    assign so_oe = out_phase & loaded & ~cs_n & ~paused;
endmodule

// File: rtl/pot_spi_front.sv
// Top of the potentiometer serial command front end: edge qualifier,
// frame decoder and read shifter. Assumes synchronised serial inputs.
module pot_spi_front
    import pot_spi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              so,
    output logic              so_oe,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [1:0]        cmd_reg,
    output logic [1:0]        cmd_bank,
    output logic [BYTE_W-1:0] cmd_data
);
    logic      frame_start, sck_rise, sck_fall, paused;
    logic      out_phase, bit_cnt_zero, load;
    cmd_kind_e kind_e;

    pot_spi_edges u_edges (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .frame_start(frame_start), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .paused(paused)
    );

    pot_spi_decoder #(.DEV_TYPE(DEV_TYPE)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .si(si), .dev_addr(dev_addr),
        .frame_start(frame_start), .sck_rise(sck_rise), .paused(paused),
        .cmd_valid(cmd_valid), .cmd_kind(kind_e), .cmd_reg(cmd_reg),
        .cmd_bank(cmd_bank), .cmd_data(cmd_data), .out_phase(out_phase),
        .bit_cnt_zero(bit_cnt_zero)
    );

    assign cmd_kind = kind_e;
    assign load     = cmd_valid && (kind_e == K_RD_WIPER || kind_e == K_RD_DREG);

    pot_spi_txshift u_tx (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(rd_data),
        .sck_fall(sck_fall), .bit_cnt_zero(bit_cnt_zero), .out_phase(out_phase),
        .cs_n(cs_n), .paused(paused), .so(so), .so_oe(so_oe)
    );

    // R11: output driver off whenever the device is deselected.
    p_oe_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);

    // R4: a driven output bit only changes after a qualified falling edge.
    p_so_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(sck_fall));
endmodule

// File: tb/pot_spi_front_tb_top.sv
module pot_spi_front_tb_top;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic [1:0] dev_addr = 2'b10;
    logic [7:0] rd_data;
    logic       so, so_oe, cmd_valid;
    logic [2:0] cmd_kind;
    logic [1:0] cmd_reg, cmd_bank;
    logic [7:0] cmd_data;
    logic [7:0] wiper_val = 8'h3c;
    logic [7:0] dr_base = 8'h96;

    int checks = 0;
    int errors = 0;
    int ev_n = 0;
    logic [2:0] ev_k [256];
    logic [1:0] ev_r [256];
    logic [1:0] ev_b [256];
    logic [7:0] ev_d [256];
    bit desel_oe = 1'b0;

    always #4 clk = ~clk;

    pot_spi_front dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .dev_addr(dev_addr), .rd_data(rd_data), .so(so), .so_oe(so_oe),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_reg(cmd_reg),
        .cmd_bank(cmd_bank), .cmd_data(cmd_data)
    );

    // Bench model of the register bank read port.
    function automatic logic [7:0] rd_fn(input logic [2:0] k, input logic [1:0] r, input logic [1:0] b);
        return (k == 3'd2) ? wiper_val : (dr_base ^ {r, b, b, r});
    endfunction
    assign rd_data = rd_fn(cmd_kind, cmd_reg, cmd_bank);

    // Command log and deselect monitor, sampled off the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && ev_n < 256) begin
                ev_k[ev_n] = cmd_kind; ev_r[ev_n] = cmd_reg;
                ev_b[ev_n] = cmd_bank; ev_d[ev_n] = cmd_data;
                ev_n++;
            end
            if (cs_n && so_oe) desel_oe = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r, output logic oe);
        si = b;
        repeat (HALF) @(negedge clk);
        r = so; oe = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    // Sends nbits of frm MSB first; collects bits 16..23 from so.
    task automatic send(input logic [23:0] frm, input int nbits, input bit touch,
                        output logic [7:0] rx, output int early_oe);
        logic r, oe;
        rx = 8'h00; early_oe = 0; ev_n = 0;
        if (touch) begin cs_n = 1'b0; repeat (HALF) @(negedge clk); end
        for (int i = 0; i < nbits; i++) begin
            sbit(frm[23-i], r, oe);
            if (i >= 16) begin
                rx = {rx[6:0], r};
                if (!oe) early_oe++;
            end else if (oe) early_oe++;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] idb(input logic [1:0] a);
        return {4'b0101, 2'b00, a};
    endfunction

    task automatic exp_none(input string tag);
        chk(ev_n == 0, tag, ev_n, 0);
    endtask

    task automatic exp_one(input logic [2:0] k, input logic [1:0] r, input logic [1:0] b,
                           input logic [7:0] d, input bit chk_rb, input bit chk_d, input string tag);
        chk(ev_n == 1, {tag, " count"}, ev_n, 1);
        if (ev_n >= 1) begin
            chk(ev_k[0] == k, {tag, " kind"}, ev_k[0], k);
            if (chk_rb) chk({ev_r[0], ev_b[0]} == {r, b}, {tag, " reg/bank"}, {ev_r[0], ev_b[0]}, {r, b});
            if (chk_d) chk(ev_d[0] == d, {tag, " data"}, ev_d[0], d);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] rx, d;
        logic [1:0] r, b;
        int eo;
        void'($urandom(32'h1d5e_a7c3));
        repeat (4) @(negedge clk);
        chk(cmd_valid == 1'b0 && so_oe == 1'b0, "R11 reset outputs idle", {cmd_valid, so_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: select held low across reset -> nothing decoded
        send({idb(2'b10), 8'b1010_0000, 8'h5a}, 24, 1'b0, rx, eo);
        exp_none("R8 no frame without select fall");

        // R3 wiper write
        d = 8'(($urandom));
        send({idb(2'b10), 8'b1010_0000, d}, 24, 1'b1, rx, eo);
        exp_one(3'd0, 2'b00, 2'b00, d, 1'b0, 1'b1, "R3 wiper write");

        // R2/R3 data register write with fields
        send({idb(2'b10), 8'b1100_1101, 8'hc3}, 24, 1'b1, rx, eo);
        exp_one(3'd1, 2'b11, 2'b01, 8'hc3, 1'b1, 1'b1, "R2 R3 dreg write");

        // R4 wiper read
        wiper_val = 8'hb6;
        send({idb(2'b10), 8'b1001_0000, 8'h00}, 24, 1'b1, rx, eo);
        exp_one(3'd2, 2'b00, 2'b00, 8'h00, 1'b0, 1'b0, "R4 wiper read");
        chk(rx == 8'hb6, "R4 wiper read so byte", rx, 8'hb6);
        chk(eo == 0, "R4 so_oe timing", eo, 0);

        // R4 dreg read
        send({idb(2'b10), 8'b1011_0110, 8'hff}, 24, 1'b1, rx, eo);
        exp_one(3'd3, 2'b01, 2'b10, 8'h00, 1'b1, 1'b0, "R4 dreg read");
        chk(rx == rd_fn(3'd3, 2'b01, 2'b10), "R4 dreg read so byte", rx, rd_fn(3'd3, 2'b01, 2'b10));

        // R5 transfers
        send({idb(2'b10), 8'b1101_1000, 8'h00}, 16, 1'b1, rx, eo);
        exp_one(3'd4, 2'b10, 2'b00, 8'h00, 1'b1, 1'b0, "R5 dr to wiper");
        send({idb(2'b10), 8'b1110_0100, 8'h00}, 16, 1'b1, rx, eo);
        exp_one(3'd5, 2'b01, 2'b00, 8'h00, 1'b1, 1'b0, "R5 wiper to dr");
        send({idb(2'b10), 8'b1110_0110, 8'h00}, 16, 1'b1, rx, eo);
        exp_none("R5 transfer bank nonzero ignored");

        // R1 mismatches
        send({idb(2'b01), 8'b1001_0000, 8'h00}, 24, 1'b1, rx, eo);
        exp_none("R1 address mismatch");
        chk(eo == 8, "R1 so_oe low after mismatch", eo, 8);
        send({8'b0111_0010, 8'b1010_0000, 8'h11}, 24, 1'b1, rx, eo);
        exp_none("R1 type nibble mismatch");
        send({8'b0101_0110, 8'b1010_0000, 8'h11}, 24, 1'b1, rx, eo);
        exp_none("R1 nonzero pad bits");

        // R9 abort before last data bit
        send({idb(2'b10), 8'b1100_0000, 8'h77}, 23, 1'b1, rx, eo);
        exp_none("R9 aborted write");

        // R10 unknown opcode
        send({idb(2'b10), 8'b0000_0000, 8'h55}, 24, 1'b1, rx, eo);
        exp_none("R10 unknown opcode");

        // R6 step stream
        begin
            logic [15:0] pat;
            logic rr, oe;
            int ok;
            pat = 16'(($urandom));
            ev_n = 0;
            cs_n = 1'b0; repeat (HALF) @(negedge clk);
            for (int i = 0; i < 16; i++) sbit(((16'({idb(2'b10), 8'b0010_0000})) >> (15 - i)) & 1'b1, rr, oe);
            for (int i = 0; i < 16; i++) sbit(pat[15-i], rr, oe);
            repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (2*HALF) @(negedge clk);
            chk(ev_n == 16, "R6 step count", ev_n, 16);
            ok = 1;
            for (int i = 0; i < 16; i++)
                if (ev_k[i] != (pat[15-i] ? 3'd6 : 3'd7)) ok = 0;
            chk(ok == 1, "R6 step directions", ok, 1);
        end

        // R7 pause mid instruction byte, junk clocks ignored
        begin
            logic [23:0] frm;
            logic rr, oe;
            frm = {idb(2'b10), 8'b1100_1001, 8'h4e};
            ev_n = 0;
            cs_n = 1'b0; repeat (HALF) @(negedge clk);
            for (int i = 0; i < 24; i++) begin
                if (i == 11) begin
                    hold_n = 1'b0; repeat (HALF) @(negedge clk);
                    for (int j = 0; j < 3; j++) sbit(j[0], rr, oe);
                    repeat (HALF) @(negedge clk);
                    hold_n = 1'b1; repeat (HALF) @(negedge clk);
                end
                sbit(frm[23-i], rr, oe);
            end
            repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (2*HALF) @(negedge clk);
            exp_one(3'd1, 2'b10, 2'b01, 8'h4e, 1'b1, 1'b1, "R7 paused write intact");
        end

        // R7 pause during read data: output released, byte still intact
        begin
            logic [23:0] frm;
            logic rr, oe;
            int oe_bad;
            wiper_val = 8'ha9;
            frm = {idb(2'b10), 8'b1001_0000, 8'h00};
            rx = 0; oe_bad = 0; ev_n = 0;
            cs_n = 1'b0; repeat (HALF) @(negedge clk);
            for (int i = 0; i < 24; i++) begin
                if (i == 20) begin
                    hold_n = 1'b0; repeat (2*HALF) @(negedge clk);
                    if (so_oe) oe_bad++;
                    hold_n = 1'b1; repeat (HALF) @(negedge clk);
                end
                sbit(frm[23-i], rr, oe);
                if (i >= 16) rx = {rx[6:0], rr};
            end
            repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (2*HALF) @(negedge clk);
            chk(oe_bad == 0, "R7 so_oe low while paused", oe_bad, 0);
            chk(rx == 8'ha9, "R7 read byte across pause", rx, 8'ha9);
        end

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int sel;
            sel = int'($urandom % 7);
            d = 8'($urandom); r = 2'($urandom); b = 2'($urandom);
            wiper_val = 8'($urandom); dr_base = 8'($urandom);
            if (($urandom % 2) == 0 && sel >= 4) b = 2'b00;
            case (sel)
                0: begin send({idb(2'b10), 4'b1010, r, b, d}, 24, 1'b1, rx, eo);
                         exp_one(3'd0, r, b, d, 1'b0, 1'b1, "R3 random wiper write"); end
                1: begin send({idb(2'b10), 4'b1100, r, b, d}, 24, 1'b1, rx, eo);
                         exp_one(3'd1, r, b, d, 1'b1, 1'b1, "R2 random dreg write"); end
                2: begin send({idb(2'b10), 4'b1001, r, b, d}, 24, 1'b1, rx, eo);
                         chk(rx == wiper_val, "R4 random wiper read", rx, wiper_val); end
                3: begin send({idb(2'b10), 4'b1011, r, b, d}, 24, 1'b1, rx, eo);
                         chk(rx == rd_fn(3'd3, r, b), "R4 random dreg read", rx, rd_fn(3'd3, r, b)); end
                4: begin send({idb(2'b10), 4'b1101, r, b, 8'h00}, 16, 1'b1, rx, eo);
                         if (b == 2'b00) exp_one(3'd4, r, b, 8'h00, 1'b1, 1'b0, "R5 random dr to wiper");
                         else exp_none("R5 random dr to wiper bank"); end
                5: begin send({idb(2'b10), 4'b1110, r, b, 8'h00}, 16, 1'b1, rx, eo);
                         if (b == 2'b00) exp_one(3'd5, r, b, 8'h00, 1'b1, 1'b0, "R5 random wiper to dr");
                         else exp_none("R5 random wiper to dr bank"); end
                default: begin send({idb(2'b10 ^ (2'($urandom % 3) + 2'd1)), 4'b1100, r, b, d}, 24, 1'b1, rx, eo);
                         exp_none("R1 random address mismatch"); end
            endcase
        end

        chk(desel_oe == 1'b0, "R11 so_oe never high while deselected", desel_oe, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule